// File: doc/BRIEF.md
# Six-Lane Transmit Serialiser with Write-Enable Gating and Output-Enable Selection

The block turns a parallel word per lane into a bit stream on six transmit lanes, and it produces one output-enable (tristate) signal per lane. A shared write-enable word is serialised through its own shift register, which advances in step with the data registers. Each serialised write-enable bit belongs to exactly one data bit, so the two stay aligned bit for bit. The ratio of bits per captured word is 8, 4 or 2 and is set by a two-bit code.

For each lane, a select bit chooses where its tristate output comes from. It can follow a direct tristate input combinationally, with no alignment to the data. It can also follow the inverted serialised write-enable, which is aligned with the lane's data bit. A separate gating enable uses the non-inverted serialised write-enable to force the lane data to zero wherever write-enable is low. One lane, lane 1, is never gated. At the 2:1 ratio the write-enable path is not allowed for tristating. Any lane that selects it there raises a configuration-error flag and falls back to the direct input.

A small sequencer has two states. SEQ_IDLE moves to SEQ_SHIFT when `run` is high. SEQ_SHIFT stays in SEQ_SHIFT and captures a new word on its last bit if `run` is still high. SEQ_SHIFT returns to SEQ_IDLE on its last bit if `run` is low. The upstream logic presents a word and holds it until it sees `word_take` high before a rising edge.

Top module: `txg_lane_ctrl`

## Requirements
- R1: After reset, and in SEQ_IDLE, every lane whose tristate source is write-enable drives `t_out` high. `tx_bit` is all zero and `word_take` is low.
- R2: `cfg_ratio` selects the bits per word: 2'b00 gives 8, 2'b01 gives 4, and 2'b10 or 2'b11 gives 2. With `run` held high, `word_take` is high in SEQ_IDLE and then once every ratio cycles, never in two consecutive cycles. A word is captured at each rising edge where `word_take` is high.
- R3: Lane l takes bits from `tx_word[l*8 +: 8]`. Bit i (LSB first, i below the ratio) drives `tx_bit[l]` during the i-th cycle after the capturing edge (i = 0 is the cycle right after it), unless gating forces it low.
- R4: A lane with `cfg_tsel` bit 0 drives `t_out` equal to its `t_direct` bit, combinationally, in any state.
- R5: A lane with `cfg_tsel` bit 1, at a ratio other than 2:1, drives `t_out` with the inverse of `wren_word` bit i in the same cycle as its data bit i.
- R6: With `cfg_gate_en` high and the serialised write-enable bit i equal to 0, `tx_bit` is 0 for every lane except lane 1. With `cfg_gate_en` low, data passes unchanged.
- R7: Lane 1 always carries its data bit, whatever the gating enable and write-enable values.
- R8: `cfg_err` is high exactly when the ratio is 2:1 and any `cfg_tsel` bit is set. Whenever it is high, every lane's `t_out` equals `t_direct`.
- R9: When `run` falls, the word in flight finishes. The sequencer then returns to SEQ_IDLE with `tx_bit` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep streaming words |
| cfg_ratio | input | 2 | Serialisation ratio code |
| cfg_tsel | input | 6 | Per-lane tristate source, 1 = write-enable |
| cfg_gate_en | input | 1 | Enable write-enable data gating |
| tx_word | input | 48 | Parallel data, 8 bits per lane |
| wren_word | input | 8 | Parallel write-enable, LSB first |
| t_direct | input | 6 | Direct tristate inputs |
| word_take | output | 1 | Word captured at the next rising edge |
| tx_bit | output | 6 | Serial data per lane |
| t_out | output | 6 | Tristate control per lane |
| cfg_err | output | 1 | Write-enable tristate requested at 2:1 |

## Verification
The hardest situation to reach is the word boundary, where a new word is captured on the same edge that the previous word's last bit leaves. A bubble or an off-by-one ratio shows only there. The driver streams several words back to back at every ratio. It presents each next word right after a capture and counts the cycles until the next `word_take`. The scoreboard then expects a gapless bit sequence. Random write-enable words mix gated and ungated bits within one word, so the exempt lane and the gated lanes are compared in the same cycle. A 2:1 run with write-enable selects exercises the fallback.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        RATIO_8TO1     = 2'b00,
        RATIO_4TO1     = 2'b01,
        RATIO_2TO1     = 2'b10,
        RATIO_2TO1_ALT = 2'b11
    } ratio_e;

    // Bits per word for a ratio code, derived from the widest ratio.
    function automatic int unsigned ratio_len(input logic [1:0] code,
                                              input int unsigned max_bits);
        if (code[1])
            return max_bits / 4;
        else if (code[0])
            return max_bits / 2;
        else
            return max_bits;
    endfunction

endpackage

// File: rtl/txg_sequencer.sv
module txg_sequencer
    import txg_pkg::*;
#(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [1:0]          ratio_in,
    output logic                load,
    output logic                busy,
    output logic [MAX_BITS-1:0] mask
);
    localparam int CNT_W = $clog2(MAX_BITS);
    localparam int LEN_W = CNT_W + 1;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [1:0]        ratio_q;
    logic [LEN_W-1:0]  len_run;
    logic [LEN_W-1:0]  len_new;
    logic              last;

    always_comb begin
        len_run = LEN_W'(ratio_len(ratio_q, MAX_BITS));
        len_new = LEN_W'(ratio_len(ratio_in, MAX_BITS));
        last    = ({1'b0, cnt_q} == (len_run - 1'b1));
        for (int i = 0; i < MAX_BITS; i++) begin
            mask[i] = (LEN_W'(i) < len_new);
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (run)          state_d = SEQ_SHIFT;
            SEQ_SHIFT: if (last && !run) state_d = SEQ_IDLE;
            default:                     state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // Bit counter and ratio held for the word in flight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RATIO_8TO1;
        end else if (load) begin
            cnt_q   <= '0;
            ratio_q <= ratio_in;
        end else if (state_q == SEQ_SHIFT) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        load = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            SEQ_IDLE:  load = run;
            SEQ_SHIFT: begin
                busy = 1'b1;
                load = run && last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/txg_shift.sv
module txg_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] word,
    output logic         bit_o
);
    logic [W-1:0] sr_q;

    // Unused upper bits are masked at capture so the register drains to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load)
            sr_q <= word & mask;
        else
            sr_q <= sr_q >> 1;
    end

    assign bit_o = sr_q[0];

endmodule

// File: rtl/txg_lane_drive.sv
module txg_lane_drive #(
    parameter bit GATEABLE = 1'b1
) (
    input  logic data_bit,
    input  logic wren_bit,
    input  logic gate_en,
    input  logic sel_wren,
    input  logic t_direct,
    output logic tx_bit,
    output logic t_out
);
    generate
        if (GATEABLE) begin : g_gated
            assign tx_bit = data_bit & ~(gate_en & ~wren_bit);
        end else begin : g_exempt
            assign tx_bit = data_bit;
        end
    endgenerate

    assign t_out = sel_wren ? ~wren_bit : t_direct;

endmodule

// File: rtl/txg_lane_ctrl.sv
module txg_lane_ctrl
    import txg_pkg::*;
#(
    parameter int LANES       = 6,
    parameter int MAX_BITS    = 8,
    parameter int EXEMPT_LANE = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic [1:0]                cfg_ratio,
    input  logic [LANES-1:0]          cfg_tsel,
    input  logic                      cfg_gate_en,
    input  logic [LANES*MAX_BITS-1:0] tx_word,
    input  logic [MAX_BITS-1:0]       wren_word,
    input  logic [LANES-1:0]          t_direct,
    output logic                      word_take,
    output logic [LANES-1:0]          tx_bit,
    output logic [LANES-1:0]          t_out,
    output logic                      cfg_err
);
    logic                load;
    logic                seq_busy;
    logic [MAX_BITS-1:0] mask;
    logic                wren_bit;
    logic                ratio_is_2;
    logic [LANES-1:0]    sel_eff;

    txg_sequencer #(.MAX_BITS(MAX_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ratio_in (cfg_ratio),
        .load     (load),
        .busy     (seq_busy),
        .mask     (mask)
    );

    txg_shift #(.W(MAX_BITS)) u_wren_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .mask  (mask),
        .word  (wren_word),
        .bit_o (wren_bit)
    );

    // The write-enable tristate path is disallowed at 2:1.
    assign ratio_is_2 = cfg_ratio[1];
    assign cfg_err    = ratio_is_2 & (|cfg_tsel);
    assign sel_eff    = cfg_tsel & ~{LANES{ratio_is_2}};
    assign word_take  = load;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic data_bit;

            txg_shift #(.W(MAX_BITS)) u_data_sr (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load),
                .mask  (mask),
                .word  (tx_word[l*MAX_BITS +: MAX_BITS]),
                .bit_o (data_bit)
            );

            txg_lane_drive #(.GATEABLE(l != EXEMPT_LANE)) u_drive (
                .data_bit (data_bit),
                .wren_bit (wren_bit),
                .gate_en  (cfg_gate_en),
                .sel_wren (sel_eff[l]),
                .t_direct (t_direct[l]),
                .tx_bit   (tx_bit[l]),
                .t_out    (t_out[l])
            );
        end
    endgenerate

endmodule

// File: rtl/txg_lane_ctrl_chk.sv
module txg_lane_ctrl_chk #(
    parameter int LANES       = 6,
    parameter int EXEMPT_LANE = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             word_take,
    input logic             cfg_err,
    input logic             cfg_gate_en,
    input logic [LANES-1:0] cfg_tsel,
    input logic [LANES-1:0] t_direct,
    input logic [LANES-1:0] t_out,
    input logic [LANES-1:0] tx_bit
);
    // R1 / R9: the idle sequencer leaves no data on the lanes.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_bit == '0));

    // R2: captures are at least two cycles apart.
    assert_take_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_take |=> !word_take);

    // R8: the error flag implies the direct fallback on every lane.
    assert_fallback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (t_out == t_direct));

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
            // R1: a write-enable lane drives its tristate high while idle.
            assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && cfg_tsel[l] && !cfg_err) |-> t_out[l]);
            if (l != EXEMPT_LANE) begin : g_gate_chk
                // R6: a write-enable high-Z bit with gating on means gated data.
                assert_gate_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (cfg_gate_en && cfg_tsel[l] && !cfg_err && t_out[l]) |-> !tx_bit[l]);
            end
        end
    endgenerate

endmodule

bind txg_lane_ctrl txg_lane_ctrl_chk #(
    .LANES       (LANES),
    .EXEMPT_LANE (EXEMPT_LANE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (seq_busy),
    .word_take   (word_take),
    .cfg_err     (cfg_err),
    .cfg_gate_en (cfg_gate_en),
    .cfg_tsel    (cfg_tsel),
    .t_direct    (t_direct),
    .t_out       (t_out),
    .tx_bit      (tx_bit)
);

// File: tb/txg_lane_ctrl_bench.sv
module txg_lane_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 6;
    localparam int MB         = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             run;
    logic [1:0]       cfg_ratio;
    logic [LANES-1:0] cfg_tsel;
    logic             cfg_gate_en;
    logic [LANES*MB-1:0] tx_word;
    logic [MB-1:0]    wren_word;
    logic [LANES-1:0] t_direct;
    logic             word_take;
    logic [LANES-1:0] tx_bit;
    logic [LANES-1:0] t_out;
    logic             cfg_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [LANES-1:0] tx;
        logic [LANES-1:0] t;
        logic [LANES-1:0] wsel;
        logic             gated;
        logic             err;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    txg_lane_ctrl u_txg_lane_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .cfg_ratio   (cfg_ratio),
        .cfg_tsel    (cfg_tsel),
        .cfg_gate_en (cfg_gate_en),
        .tx_word     (tx_word),
        .wren_word   (wren_word),
        .t_direct    (t_direct),
        .word_take   (word_take),
        .tx_bit      (tx_bit),
        .t_out       (t_out),
        .cfg_err     (cfg_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver side: expected items for one captured word.
    task automatic push_word(input int len, input logic [LANES-1:0] wsel,
                             input logic gate, input logic [LANES-1:0] tdir,
                             input logic err);
        for (int i = 0; i < len; i++) begin
            exp_t e;
            logic w;
            w       = wren_word[i];
            e.gated = gate && !w;
            e.wsel  = wsel;
            e.err   = err;
            for (int l = 0; l < LANES; l++) begin
                e.tx[l] = (e.gated && l != 1) ? 1'b0 : tx_word[l*MB + i];
                e.t[l]  = wsel[l] ? ~w : tdir[l];
            end
            exp_q.push_back(e);
        end
    endtask

    // Monitor: one expected item per cycle while the scoreboard holds any.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int l = 0; l < LANES; l++) begin
                string tg;
                if (l == 1)       tg = "R7";
                else if (e.gated) tg = "R6";
                else              tg = "R3";
                check(tx_bit[l] == e.tx[l], tg, $sformatf("tx_bit lane %0d", l),
                      int'(tx_bit[l]), int'(e.tx[l]));
                if (e.wsel[l])   tg = "R5";
                else if (e.err)  tg = "R8";
                else             tg = "R4";
                check(t_out[l] == e.t[l], tg, $sformatf("t_out lane %0d", l),
                      int'(t_out[l]), int'(e.t[l]));
            end
        end
    end

    task automatic new_word(input int wmode);
        tx_word = 48'({$urandom(), $urandom()});
        if (wmode == 1)      wren_word = '0;
        else if (wmode == 2) wren_word = '1;
        else                 wren_word = 8'($urandom());
    endtask

    task automatic run_stream(input logic [1:0] ratio, input logic [LANES-1:0] tsel,
                              input logic gate, input logic [LANES-1:0] tdir,
                              input int nwords, input int wmode);
        int len;
        logic [LANES-1:0] wsel;
        logic experr;
        len    = ratio[1] ? 2 : (ratio[0] ? 4 : 8);
        wsel   = ratio[1] ? '0 : tsel;
        experr = ratio[1] && (|tsel);
        @(negedge clk);
        cfg_ratio   = ratio;
        cfg_tsel    = tsel;
        cfg_gate_en = gate;
        t_direct    = tdir;
        new_word(wmode);
        run = 1'b1;
        #1;
        check(word_take == 1'b1, "R2", "word_take from idle", int'(word_take), 1);
        check(cfg_err == experr, "R8", "cfg_err", int'(cfg_err), int'(experr));
        @(posedge clk);
        push_word(len, wsel, gate, tdir, experr);
        for (int w = 1; w < nwords; w++) begin
            int gap;
            @(negedge clk);
            new_word(wmode);
            gap = 1;
            while (!word_take && gap < 20) begin
                @(negedge clk);
                gap++;
            end
            check(gap == len, "R2", "capture spacing", gap, len);
            @(posedge clk);
            push_word(len, wsel, gate, tdir, experr);
        end
        @(negedge clk);
        run = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(tx_bit == '0, "R9", "tx_bit after stop", int'(tx_bit), 0);
        check(word_take == 1'b0, "R9", "word_take after stop", int'(word_take), 0);
        check((t_out & wsel) == wsel, "R1", "idle t_out on write-enable lanes",
              int'(t_out & wsel), int'(wsel));
        // R4: direct lanes follow t_direct with no clock edge.
        t_direct = ~tdir;
        #1;
        check((t_out & ~wsel) == (~tdir & ~wsel), "R4", "direct t_out combinational",
              int'(t_out & ~wsel), int'(~tdir & ~wsel));
        t_direct = tdir;
    endtask

    initial begin
        rst_n       = 1'b0;
        run         = 1'b0;
        cfg_ratio   = 2'b00;
        cfg_tsel    = '1;
        cfg_gate_en = 1'b0;
        tx_word     = '0;
        wren_word   = '0;
        t_direct    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit == '0, "R1", "tx_bit after reset", int'(tx_bit), 0);
        check(word_take == 1'b0, "R1", "word_take after reset", int'(word_take), 0);
        check(t_out == '1, "R1", "t_out after reset", int'(t_out), 63);
        check(cfg_err == 1'b0, "R8", "cfg_err at 8:1", int'(cfg_err), 0);

        run_stream(2'b00, 6'b101010, 1'b0, 6'b010101, 6, 0);
        run_stream(2'b01, 6'b010101, 1'b1, 6'b101010, 6, 0);
        run_stream(2'b10, 6'b000000, 1'b1, 6'b110011, 8, 0);
        run_stream(2'b11, 6'b000011, 1'b1, 6'b011110, 6, 0);
        run_stream(2'b00, 6'b111111, 1'b1, 6'b000000, 3, 1);
        run_stream(2'b01, 6'b100001, 1'b1, 6'b010010, 4, 2);
        run_stream(2'b00, 6'b001100, 1'b1, 6'b000000, 8, 0);
        run_stream(2'b10, 6'b100000, 1'b0, 6'b101101, 5, 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule